// File: doc/BRIEF.md
# Programmable Interval Timer with Falling-Edge Prescaler

This block is a programmable interval timer. A 16-bit free-running divider advances once for each cycle strobe. One divider bit is chosen by a two-bit rate field and ANDed with an enable bit. Each high-to-low transition of that product advances an 8-bit count register. When the count steps past 0xFF, it reloads from a modulo register and raises a one-cycle interrupt request.

Software reaches four byte-wide registers through a small write/read port:

| Address | Register |
|---|---|
| 0 | divider (upper byte) |
| 1 | count |
| 2 | modulo |
| 3 | control |

The product is recomputed from the next divider and control values on every clock. A divider clear or a control write that pulls the product low therefore counts as an edge, in the same way as a natural divider transition. Bus decoding and interrupt routing are outside this block.

Top module: `prog_timer`

## Requirements
- R1: After reset the divider, count, modulo and control registers all read 0 and `irq` is low.
- R2: The divider increments by one, with wraparound, on each clock where `tick` is high. A read of address 0 returns divider bits 15:8.
- R3: Any write to address 0 clears all 16 divider bits, whatever the data and whatever the `tick` input.
- R4: Control (address 3) bit 2 is the enable. Bits 1:0 pick the tapped divider bit: 00 taps bit 9, 01 taps bit 3, 10 taps bit 5 and 11 taps bit 7. Reads return the three stored bits, zero-extended.
- R5: The count increments only when the tapped bit ANDed with the enable goes from 1 to 0. A 0-to-1 transition has no effect, and nothing counts while the enable is 0. The stored product is 0 after reset, so the first evaluation cannot increment.
- R6: An increment from 0xFF loads the modulo value (address 2) into the count. `irq` is then high for exactly one cycle, the cycle after that clock edge.
- R7: A control write or a divider clear that takes the product from 1 to 0 increments the count once.
- R8: A write to address 1 sets the count. A write in the same cycle as an increment takes priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Cycle strobe that advances the divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | One-cycle timer interrupt request |

## Verification
The count is driven by each of the four rates over whole tap periods, so that a wrong bit choice shows up as a wrong count. A half-period run separates falling-edge counting from rising-edge counting. A run with the enable cleared shows that the tapped bit alone does nothing. A preset near 0xFF separates the plain increment from the reload, and confirms that `irq` pulses exactly once. Forced transitions are made three ways: clearing the enable, clearing the divider, and switching the rate to a low bit. Each is done while the product is high, and each must add exactly one count.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        RATE_SLOW    = 2'b00,
        RATE_FASTEST = 2'b01,
        RATE_FAST    = 2'b10,
        RATE_MID     = 2'b11
    } rate_e;

    localparam logic [1:0] ADDR_DIV  = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_MOD  = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    localparam int CTRL_W   = 3;
    localparam int CTRL_EN  = 2;
endpackage

// File: rtl/tmr_tap.sv
module tmr_tap
    import timer_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int TAP_SLOW    = 9,
    parameter int TAP_FASTEST = 3,
    parameter int TAP_FAST    = 5,
    parameter int TAP_MID     = 7
) (
    input  logic [DIV_W-1:0] div,
    input  rate_e            rate,
    input  logic             enable,
    output logic             product
);
    logic tapped;

    always_comb begin
        unique case (rate)
            RATE_SLOW:    tapped = div[TAP_SLOW];
            RATE_FASTEST: tapped = div[TAP_FASTEST];
            RATE_FAST:    tapped = div[TAP_FAST];
            default:      tapped = div[TAP_MID];
        endcase
        product = tapped & enable;
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld_cnt,
    input  logic             ld_mod,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cnt,
    output logic [REG_W-1:0] modv,
    output logic             irq
);
    localparam logic [REG_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] modv;
        logic             irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (ld_cnt) begin
            st_d.cnt = wdata;
        end else if (inc) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.cnt = st_q.modv;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + REG_W'(1);
            end
        end
        if (ld_mod) st_d.modv = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign modv = st_q.modv;
    assign irq  = st_q.irq;
endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import timer_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int REG_W       = 8,
    parameter int TAP_SLOW    = 9,
    parameter int TAP_FASTEST = 3,
    parameter int TAP_FAST    = 5,
    parameter int TAP_MID     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [CTRL_W-1:0] ctrl;
        logic              prev;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [DIV_W-1:0]  div_d;
    logic [CTRL_W-1:0] ctrl_d;
    logic              prod_d;
    logic              fall;
    logic              wr_div, wr_cnt, wr_mod, wr_ctrl;
    logic [REG_W-1:0]  cnt_q, mod_q;

    assign wr_div  = wr_en && (addr == ADDR_DIV);
    assign wr_cnt  = wr_en && (addr == ADDR_CNT);
    assign wr_mod  = wr_en && (addr == ADDR_MOD);
    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);

    // next divider and control, evaluated ahead of the tap
    always_comb begin
        div_d  = st_q.div;
        ctrl_d = st_q.ctrl;
        if (wr_div)    div_d = '0;
        else if (tick) div_d = st_q.div + DIV_W'(1);
        if (wr_ctrl)   ctrl_d = wr_data[CTRL_W-1:0];
    end

    tmr_tap #(
        .DIV_W(DIV_W), .TAP_SLOW(TAP_SLOW), .TAP_FASTEST(TAP_FASTEST),
        .TAP_FAST(TAP_FAST), .TAP_MID(TAP_MID)
    ) u_tap (
        .div    (div_d),
        .rate   (rate_e'(ctrl_d[1:0])),
        .enable (ctrl_d[CTRL_EN]),
        .product(prod_d)
    );

    always_comb begin
        st_d.div  = div_d;
        st_d.ctrl = ctrl_d;
        st_d.prev = prod_d;
        fall      = st_q.prev & ~prod_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_count #(.REG_W(REG_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fall),
        .ld_cnt(wr_cnt),
        .ld_mod(wr_mod),
        .wdata (wr_data),
        .cnt   (cnt_q),
        .modv  (mod_q),
        .irq   (irq)
    );

    always_comb begin
        unique case (addr)
            ADDR_DIV: rd_data = st_q.div[DIV_W-1 -: REG_W];
            ADDR_CNT: rd_data = cnt_q;
            ADDR_MOD: rd_data = mod_q;
            default:  rd_data = REG_W'(st_q.ctrl);
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DIV_W = 16,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic             irq,
    input logic [DIV_W-1:0] div_q,
    input logic [REG_W-1:0] cnt_q,
    input logic [REG_W-1:0] mod_q,
    input logic [2:0]       ctrl_q,
    input logic             fall
);
    localparam logic [REG_W-1:0] CNT_MAX = '1;

    assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && addr == 2'd0)) |=> div_q == $past(div_q) + DIV_W'(1));

    assert_div_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> div_q == '0);

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !(wr_en && addr == 2'd1)) |=> $stable(cnt_q));

    assert_no_count_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[2] && !wr_en) |=> $stable(cnt_q));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && cnt_q == CNT_MAX && !(wr_en && addr == 2'd1))
        |=> (cnt_q == $past(mod_q) && irq));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> !irq);
endmodule

bind prog_timer tmr_checker #(.DIV_W(DIV_W), .REG_W(REG_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_en (wr_en),
    .addr  (addr),
    .irq   (irq),
    .div_q (st_q.div),
    .cnt_q (cnt_q),
    .mod_q (mod_q),
    .ctrl_q(st_q.ctrl),
    .fall  (fall)
);

// File: tb/tb_prog_timer.sv
module tb_prog_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    int irq_seen = 0;

    prog_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (irq) irq_seen++;

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic prep(input logic [7:0] ctrl);
        wr(2'd3, ctrl);
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register after reset", v, 0);
        end
        check("R1 irq after reset", irq, 0);
    endtask

    task automatic t_divider;
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v);
        check("R3 divider cleared", v, 0);
        ticks(512);
        rd(2'd0, v);
        check("R2 divider upper byte after 512", v, 2);
        ticks(65536 - 512);
        rd(2'd0, v);
        check("R2 divider wraps", v, 0);
        ticks(300);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(2'd0, v);
        check("R3 clear beats tick", v, 0);
    endtask

    task automatic t_rate(input logic [1:0] sel, input int period, input string req);
        logic [7:0] v;
        prep({5'b0, 1'b1, sel});
        ticks(period * 3);
        rd(2'd1, v);
        check(req, v, 3);
        rd(2'd3, v);
        check("R4 control readback", v, {5'b0, 1'b1, sel});
    endtask

    task automatic t_edge_sense;
        logic [7:0] v;
        prep(8'h05);
        ticks(8);
        rd(2'd1, v);
        check("R5 rising edge does not count", v, 0);
        ticks(8);
        rd(2'd1, v);
        check("R5 falling edge counts", v, 1);
        prep(8'h01);
        ticks(64);
        rd(2'd1, v);
        check("R5 disabled no count", v, 0);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        prep(8'h05);
        wr(2'd2, 8'h40);
        wr(2'd1, 8'hFE);
        irq_seen = 0;
        ticks(16);
        rd(2'd1, v);
        check("R6 step to FF", v, 8'hFF);
        check("R6 no irq before wrap", irq_seen, 0);
        ticks(16);
        repeat (2) @(negedge clk);
        rd(2'd1, v);
        check("R6 reload from modulo", v, 8'h40);
        check("R6 single irq pulse", irq_seen, 1);
    endtask

    task automatic t_forced;
        logic [7:0] v;
        prep(8'h05);
        ticks(8);
        wr(2'd3, 8'h01);
        rd(2'd1, v);
        check("R7 enable clear counts", v, 1);
        wr(2'd3, 8'h05);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        check("R7 divider clear counts", v, 2);
        ticks(8);
        wr(2'd3, 8'h06);
        rd(2'd1, v);
        check("R7 rate switch counts", v, 3);
    endtask

    task automatic t_write_priority;
        logic [7:0] v;
        prep(8'h05);
        ticks(15);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 2'd1; wr_data = 8'h77;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(2'd1, v);
        check("R8 write wins over increment", v, 8'h77);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider();
        t_rate(2'b00, 1024, "R4 tap bit 9");
        t_rate(2'b01, 16,   "R4 tap bit 3");
        t_rate(2'b10, 64,   "R4 tap bit 5");
        t_rate(2'b11, 256,  "R4 tap bit 7");
        t_edge_sense();
        t_overflow();
        t_forced();
        t_write_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule